// File: doc/BRIEF.md
# Serial Receive Buffer

This block turns an asynchronous serial stream on one input line into parallel characters. Each character goes into a small receive store together with three status bits: parity error, framing error and line break. Software sets the bit time as a divisor of the system clock. The receiver works on ticks at sixteen times the bit rate. It confirms a start bit halfway through the bit and then samples every later bit at its centre.

Word length (5 to 8 bits), parity (none, odd or even) and stop length (1, 1.5 or 2 bits) are inputs to the block. After reset the store acts as a one-character holding location. With the buffer mode input set, it becomes a 16-entry first-in first-out queue. The consumer sees the oldest entry on the read outputs and pops it with a one-cycle read strobe. A data-ready flag, a sticky overrun flag and an interrupt request summarise the state of the store.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset, data_ready_o, overrun_o and irq_o are 0 and the store is in single-character mode whenever fifo_mode_i is 0.
- R2: A frame is one low start bit, then data bits least significant first, with 5 + word_len_i bits (word_len_i 0..3). One bit lasts 16 × baud_div_i clock cycles. Unused upper bits of rd_data_o read 0.
- R3: A frame is received correctly when each start, data, parity and stop bit lasts anywhere from 0.96 to 1.05 of the nominal bit time.
- R4: With par_en_i = 1, a parity bit follows the data bits. par_even_i = 1 expects an even number of ones over data plus parity, and 0 expects an odd number. On a mismatch rd_perr_o is 1 for that entry. With par_en_i = 0, no parity bit is expected and rd_perr_o is 0.
- R5: stop_sel_i = 0, 1 or 2 selects 1, 1.5 or 2 stop bits (3 acts as 2). Every stop sample is taken at the centre of its portion, and any of them seen low sets rd_ferr_o for that entry.
- R6: A frame whose data, parity and stop samples are all low is stored with rd_brk_o = 1, rd_ferr_o = 1 and data 0. The receiver then waits for the line to go high before it accepts a new start bit.
- R7: A low pulse that has ended by the middle of the start bit is discarded: nothing is stored, and the next valid frame is received normally.
- R8: In single-character mode the store holds one entry. A character that completes while that entry is unread is dropped, the held character is kept, and overrun_o is set.
- R9: In FIFO mode the store holds 16 entries, read back in arrival order. A 17th character that arrives while all 16 are unread is dropped and sets overrun_o.
- R10: overrun_o stays 1 until a cycle with rd_en_i = 1 in which no character is dropped. That cycle clears it.
- R11: In single-character mode irq_o equals data_ready_o. In FIFO mode irq_o is 1 when the fill level is at least the trigger selected by trig_sel_i (0:1, 1:4, 2:8, 3:14).
- R12: A change of fifo_mode_i discards every stored entry, so data_ready_o is 0 on the following cycle.
- R13: rd_data_o, rd_perr_o, rd_ferr_o and rd_brk_o show the oldest entry while data_ready_o is 1. rd_en_i removes that entry, and rd_en_i on an empty store changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | DIV_W | Clock cycles per oversampling tick |
| word_len_i | input | 2 | Data bits minus five |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel_i | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| fifo_mode_i | input | 1 | 0 = single-character store, 1 = 16-entry queue |
| trig_sel_i | input | 2 | FIFO interrupt threshold select |
| rd_en_i | input | 1 | Pop the oldest entry |
| rd_data_o | output | 8 | Oldest character |
| rd_perr_o | output | 1 | Parity error of oldest entry |
| rd_ferr_o | output | 1 | Framing error of oldest entry |
| rd_brk_o | output | 1 | Break flag of oldest entry |
| data_ready_o | output | 1 | Store not empty |
| overrun_o | output | 1 | Sticky character-lost flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench sends frames in which each bit width is drawn at random from the accepted window, with the accumulated skew kept bounded. A receiver that samples away from the bit centre would therefore pick up a neighbouring bit. It injects parity and stop errors, holds the line low for a whole frame, and sends a start glitch a few ticks long. A design that tagged entries wrongly, stored a break twice or latched a phantom character would report wrong status bits or extra entries. It fills both store modes past capacity, reads from an empty store and toggles the mode with data pending. These cases expose an overwrite of the oldest entry, an overrun flag that clears early, a wrong interrupt threshold and stale entries that survive the mode change.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } srx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } srx_state_t;

    function automatic int srx_trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t            t_q, t_d;
    logic [DIV_W-1:0] last;

    always_comb begin
        last   = (div_i <= 1) ? '0 : div_i - 1'b1;
        tick_o = (t_q.cnt >= last);
        t_d    = t_q;
        if (tick_o) t_d.cnt = '0;
        else        t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rxd_i,
    input  logic [1:0] word_len_i,
    input  logic       par_en_i,
    input  logic       par_even_i,
    input  logic [1:0] stop_sel_i,
    output logic       push_o,
    output srx_entry_t entry_o
);

    localparam int            CW    = $clog2(OVS);
    localparam logic [CW-1:0] T_MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] T_HALF = CW'((OVS * 3) / 4 - 1);
    localparam logic [CW-1:0] T_FULL = CW'(OVS - 1);

    typedef struct packed {
        srx_state_t st;
        logic [1:0] sync;
        logic       armed;
        logic [CW-1:0] cnt;
        logic [2:0] bit_idx;
        logic       extra;
        logic [7:0] data;
        logic       par_acc;
        logic       perr;
        logic       ferr;
        logic       all_low;
        logic       push;
        srx_entry_t ent;
    } frame_t;

    frame_t        f_q, f_d;
    logic          s;
    logic [CW-1:0] target;
    logic [2:0]    last_idx;

    always_comb begin
        s        = f_q.sync[1];
        last_idx = {1'b1, word_len_i};
        case (f_q.st)
            ST_START: target = T_MID;
            ST_STOP:  target = (f_q.extra && stop_sel_i == 2'd1) ? T_HALF : T_FULL;
            default:  target = T_FULL;
        endcase

        f_d      = f_q;
        f_d.push = 1'b0;
        f_d.sync = {f_q.sync[0], rxd_i};

        if (tick_i) begin
            if (f_q.st == ST_IDLE) begin
                if (s) begin
                    f_d.armed = 1'b1;
                end else if (f_q.armed) begin
                    f_d.st    = ST_START;
                    f_d.cnt   = '0;
                    f_d.armed = 1'b0;
                end
            end else if (f_q.cnt != target) begin
                f_d.cnt = f_q.cnt + 1'b1;
            end else begin
                f_d.cnt = '0;
                unique case (f_q.st)
                    ST_START: begin
                        if (!s) begin
                            f_d.st      = ST_DATA;
                            f_d.bit_idx = '0;
                            f_d.data    = '0;
                            f_d.par_acc = 1'b0;
                            f_d.perr    = 1'b0;
                            f_d.ferr    = 1'b0;
                            f_d.all_low = 1'b1;
                        end else begin
                            f_d.st = ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        f_d.data[f_q.bit_idx] = s;
                        f_d.par_acc = f_q.par_acc ^ s;
                        f_d.all_low = f_q.all_low & ~s;
                        if (f_q.bit_idx == last_idx) begin
                            f_d.st    = par_en_i ? ST_PAR : ST_STOP;
                            f_d.extra = 1'b0;
                        end else begin
                            f_d.bit_idx = f_q.bit_idx + 3'd1;
                        end
                    end
                    ST_PAR: begin
                        f_d.perr    = par_even_i ? (f_q.par_acc ^ s) : ~(f_q.par_acc ^ s);
                        f_d.all_low = f_q.all_low & ~s;
                        f_d.st      = ST_STOP;
                        f_d.extra   = 1'b0;
                    end
                    ST_STOP: begin
                        f_d.ferr    = f_q.ferr | ~s;
                        f_d.all_low = f_q.all_low & ~s;
                        if (!f_q.extra && stop_sel_i != 2'd0) begin
                            f_d.extra = 1'b1;
                        end else begin
                            f_d.push     = 1'b1;
                            f_d.ent.brk  = f_d.all_low;
                            f_d.ent.ferr = f_d.ferr;
                            f_d.ent.perr = f_q.perr;
                            f_d.ent.data = f_q.data;
                            f_d.st       = ST_IDLE;
                            f_d.armed    = s;
                        end
                    end
                    default: f_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.st   <= ST_IDLE;
            f_q.sync <= 2'b11;
        end else begin
            f_q <= f_d;
        end
    end

    assign push_o  = f_q.push;
    assign entry_o = f_q.ent;

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.push |=> !f_q.push); // R2
    AST_BRK_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.push && f_q.ent.brk) |-> (f_q.ent.ferr && f_q.ent.data == 8'd0)); // R6

endmodule

// File: rtl/srx_queue.sv
module srx_queue
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  srx_entry_t                   entry_i,
    input  logic                         fifo_mode_i,
    input  logic                         rd_en_i,
    output srx_entry_t                   head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         overrun_o
);

    localparam int            AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int            CW     = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovr;
        logic          mode;
    } queue_t;

    queue_t        q_q, q_d;
    srx_entry_t    mem [DEPTH];
    logic [CW-1:0] limit;
    logic          flush, pop, accept, drop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d    = q_q;
        limit  = q_q.mode ? FULL_N : CW'(1);
        flush  = (fifo_mode_i != q_q.mode);
        pop    = rd_en_i && (q_q.cnt != '0) && !flush;
        accept = push_i && !flush && ((q_q.cnt < limit) || pop);
        drop   = push_i && !flush && !accept;

        if (flush) begin
            q_d.wr   = '0;
            q_d.rd   = '0;
            q_d.cnt  = '0;
            q_d.mode = fifo_mode_i;
        end else begin
            if (pop)    q_d.rd = nxt(q_q.rd);
            if (accept) q_d.wr = nxt(q_q.wr);
            case ({accept, pop})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end

        if (drop)         q_d.ovr = 1'b1;
        else if (rd_en_i) q_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[q_q.wr] <= entry_i;
    end

    assign head_o    = mem[q_q.rd];
    assign count_o   = q_q.cnt;
    assign overrun_o = q_q.ovr;

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= limit); // R9
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (q_q.cnt == $past(q_q.cnt) && q_q.ovr)); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.ovr && !rd_en_i) |=> q_q.ovr); // R10
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_q.cnt == '0)); // R12
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && q_q.cnt == '0 && !push_i) |=> (q_q.cnt == '0)); // R13

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import srx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_i,
    input  logic [DIV_W-1:0] baud_div_i,
    input  logic [1:0]       word_len_i,
    input  logic             par_en_i,
    input  logic             par_even_i,
    input  logic [1:0]       stop_sel_i,
    input  logic             fifo_mode_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             rd_en_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_perr_o,
    output logic             rd_ferr_o,
    output logic             rd_brk_o,
    output logic             data_ready_o,
    output logic             overrun_o,
    output logic             irq_o
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          tick;
    logic          push;
    srx_entry_t    entry;
    srx_entry_t    head;
    logic [CW-1:0] count;

    srx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (baud_div_i),
        .tick_o (tick)
    );

    srx_frame #(.OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rxd_i      (rxd_i),
        .word_len_i (word_len_i),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .stop_sel_i (stop_sel_i),
        .push_o     (push),
        .entry_o    (entry)
    );

    srx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .entry_i     (entry),
        .fifo_mode_i (fifo_mode_i),
        .rd_en_i     (rd_en_i),
        .head_o      (head),
        .count_o     (count),
        .overrun_o   (overrun_o)
    );

    always_comb begin
        rd_data_o    = head.data;
        rd_perr_o    = head.perr;
        rd_ferr_o    = head.ferr;
        rd_brk_o     = head.brk;
        data_ready_o = (count != '0);
        if (fifo_mode_i) irq_o = (int'(count) >= srx_trig_level(trig_sel_i));
        else             irq_o = data_ready_o;
    end

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> data_ready_o); // R11

endmodule

// File: tb/tb_serial_rx_buffer.sv
module tb_serial_rx_buffer;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rxd;
    logic [15:0] baud_div;
    logic [1:0]  word_len;
    logic        par_en, par_even;
    logic [1:0]  stop_sel;
    logic        fifo_mode;
    logic [1:0]  trig_sel;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic        rd_perr, rd_ferr, rd_brk;
    logic        data_ready, overrun, irq;

    int total = 0;
    int bad = 0;
    int drift = 0;
    int bit_clks = 32;
    logic [10:0] expq [0:31];
    int ecnt = 0;

    always #(CLK_P / 2) clk = ~clk;

    serial_rx_buffer dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .baud_div_i(baud_div),
        .word_len_i(word_len), .par_en_i(par_en), .par_even_i(par_even),
        .stop_sel_i(stop_sel), .fifo_mode_i(fifo_mode), .trig_sel_i(trig_sel),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_perr_o(rd_perr),
        .rd_ferr_o(rd_ferr), .rd_brk_o(rd_brk), .data_ready_o(data_ready),
        .overrun_o(overrun), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int trig_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [10:0] expect_of(input logic [7:0] d, input bit bp, input bit bs);
        logic [7:0] mask;
        mask = 8'hFF >> (3 - word_len);
        return {1'b0, bs, bp & par_en, d & mask};
    endfunction

    task automatic set_div(input int dv);
        baud_div = 16'(dv);
        bit_clks = 16 * dv;
    endtask

    // R3: each width picked in 0.96..1.05 of nominal, skew steered back toward zero
    task automatic hold(input logic v, input int nom);
        int k;
        int w;
        if (drift > 0) k = 96 + int'($urandom % 5);
        else           k = 100 + int'($urandom % 6);
        w = (nom * k + 50) / 100;
        rxd = v;
        #(w * CLK_P);
        drift += w - nom;
    endtask

    task automatic send(input logic [7:0] d, input bit bp, input bit bs);
        logic p;
        int   n;
        n = 5 + int'(word_len);
        drift = 0;
        hold(1'b0, bit_clks);
        for (int i = 0; i < n; i++) hold(d[i], bit_clks);
        if (par_en) begin
            p = 1'b0;
            for (int i = 0; i < n; i++) p ^= d[i];
            if (!par_even) p = ~p;
            hold(p ^ bp, bit_clks);
        end
        hold(!bs, bit_clks);
        if (stop_sel == 2'd1) hold(!bs, bit_clks / 2);
        if (stop_sel >= 2'd2) hold(!bs, bit_clks);
        rxd = 1'b1;
        if (bs) #(bit_clks * CLK_P);
    endtask

    task automatic settle();
        #(2 * bit_clks * CLK_P);
        @(negedge clk);
    endtask

    task automatic read_check(input logic [10:0] exp, input string req);
        @(negedge clk);
        chk({req, " data_ready"}, int'(data_ready), 1);
        chk({req, " entry"}, int'({rd_brk, rd_ferr, rd_perr, rd_data}), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < ecnt; i++) read_check(expq[i], req);
        @(negedge clk);
        chk({req, " empty after drain"}, int'(data_ready), 0);
        ecnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit bp, bs;
        int n;
        void'($urandom(32'h5A17));
        rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0;
        word_len = 2'd3; par_en = 1'b0; par_even = 1'b0; stop_sel = 2'd0;
        fifo_mode = 1'b0; trig_sel = 2'd0;
        set_div(2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 irq", int'(irq), 0);

        // R2 R11 single character, irq follows data_ready
        word_len = 2'd1;
        send(8'hB5, 0, 0);
        settle();
        chk("R11 single irq", int'(irq), 1);
        read_check(expect_of(8'hB5, 0, 0), "R2 six-bit char");
        chk("R11 single irq clears", int'(irq), 0);

        // R8 R10 single-character overrun
        word_len = 2'd3;
        send(8'h3C, 0, 0);
        send(8'hC3, 0, 0);
        settle();
        chk("R8 overrun set", int'(overrun), 1);
        read_check(expect_of(8'h3C, 0, 0), "R8 held char kept");
        chk("R10 overrun cleared by read", int'(overrun), 0);
        chk("R8 second char dropped", int'(data_ready), 0);

        // R13 read on empty store
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R13 empty read data_ready", int'(data_ready), 0);
        send(8'h5A, 0, 0);
        settle();
        read_check(expect_of(8'h5A, 0, 0), "R13 after empty read");

        // R4 R5 R3 R9 R11 random frames in FIFO mode
        fifo_mode = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            set_div(2 + int'($urandom % 2));
            word_len = 2'($urandom);
            par_en   = 1'($urandom);
            par_even = 1'($urandom);
            stop_sel = 2'($urandom % 3);
            trig_sel = 2'($urandom);
            n = 1 + int'($urandom % 12);
            @(negedge clk);
            for (int i = 0; i < n; i++) begin
                d  = 8'($urandom);
                bp = par_en && ($urandom % 4 == 0);
                bs = ($urandom % 5 == 0);
                if (bs) d[0] = 1'b1;
                send(d, bp, bs);
                expq[ecnt] = expect_of(d, bp, bs);
                ecnt++;
            end
            settle();
            chk("R11 fifo trigger", int'(irq), int'(n >= trig_of(trig_sel)));
            drain("R4 R5 R3 random frame");
        end

        // R9 fill past capacity
        set_div(2); word_len = 2'd3; par_en = 1'b1; par_even = 1'b1;
        stop_sel = 2'd1; trig_sel = 2'd3;
        @(negedge clk);
        for (int i = 0; i < 17; i++) begin
            d = 8'(i * 37 + 5);
            send(d, 0, 0);
            if (i < 16) begin
                expq[ecnt] = expect_of(d, 0, 0);
                ecnt++;
            end
        end
        settle();
        chk("R9 overrun on 17th", int'(overrun), 1);
        chk("R11 trigger 14 reached", int'(irq), 1);
        drain("R9 order kept");

        // R6 break
        par_en = 1'b0; stop_sel = 2'd0; trig_sel = 2'd0;
        @(negedge clk);
        rxd = 1'b0;
        #(12 * bit_clks * CLK_P);
        rxd = 1'b1;
        settle();
        expq[0] = 11'h600;
        ecnt = 1;
        drain("R6 break stored once");

        // R7 start glitch
        rxd = 1'b0;
        #(3 * 2 * CLK_P);
        rxd = 1'b1;
        settle();
        chk("R7 glitch ignored", int'(data_ready), 0);
        send(8'hE7, 0, 0);
        settle();
        read_check(expect_of(8'hE7, 0, 0), "R7 next frame ok");

        // R12 mode change flush
        stop_sel = 2'd2;
        for (int i = 0; i < 3; i++) send(8'(8'h11 * i + 8'h21), 0, 0);
        settle();
        chk("R12 data before flush", int'(data_ready), 1);
        fifo_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R12 flushed", int'(data_ready), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule